// File: doc/BRIEF.md
# Key-Locked Function-Select Guard

This block holds an 8-bit function-select register whose bits choose between ordinary and alternate use of a set of pins. A stray write must not change it, so it is protected at two levels. A lock flag opens only when one exact 32-bit key is written to it. While the flag is open, a commit mask may be rewritten. Each set bit of that mask permits a write to the matching bit of the function-select register.

Software first writes the key, then sets the commit mask, and then writes the function-select register. Bits whose commit bit is clear keep their old value. Any write of a value other than the key closes the lock again. The lock does not close by itself after a commit write. All three registers read back through a simple synchronous register port. Reads are combinational and writes take effect on the clock edge.

Top module: `keyguard_top`

## Requirements
- R1: After reset the lock reads 1 (locked), the commit mask reads 0xFF and the function-select register reads 0x00.
- R2: A write of 0x0ACCE551 to offset 0x520 makes the lock read 0 from the next cycle.
- R3: A write of any other 32-bit value to offset 0x520 makes the lock read 1 from the next cycle.
- R4: A write to offset 0x524 while unlocked loads bits [7:0] of the write data into the commit mask. The upper bits are dropped.
- R5: A write to offset 0x524 while locked leaves the commit mask unchanged.
- R6: A write to offset 0x420 updates only the function-select bits whose commit bit is 1. All other bits keep their previous value. This holds whatever the lock state is.
- R7: The lock state changes only on a write to offset 0x520 or on reset. Writes to the other offsets leave it unchanged.
- R8: Reads at 0x520, 0x524 and 0x420 return the lock flag in bit 0, the commit mask in bits [7:0] and the function-select value in bits [7:0] respectively, with zero upper bits. Any other offset reads 0.
- R9: The output `func_sel` always equals the function-select register.
- R10: A write to an unmapped offset changes none of the three registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 12 | Byte offset of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| func_sel | output | 8 | Current function-select bits toward the pin multiplexer |

## Verification
The bench uses the default parameters: an 8-bit select width, a 12-bit offset and the 0x0ACCE551 key. This is enough to try an almost-correct key, a key with its upper bits set, and commit masks that are full, empty or split between nibbles. The split-nibble cases show that partial updates keep exactly the bits whose commit bit is clear. Unlocked, relocked and unmapped-offset sequences are compared against a behavioural model on every clock.

// File: rtl/keyguard_pkg.sv
package keyguard_pkg;
  // bitwise merge: bits set in en take nxt, others keep cur
  function automatic logic [31:0] masked_merge(logic [31:0] cur, logic [31:0] nxt,
                                               logic [31:0] en);
    return (cur & ~en) | (nxt & en);
  endfunction

  function automatic logic key_opens(logic [31:0] data, logic [31:0] key);
    return data == key;
  endfunction
endpackage

// File: rtl/keyguard_lock.sv
module keyguard_lock #(
  parameter int          DATA_W = 32,
  parameter logic [31:0] KEY    = 32'h0ACC_E551
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lock,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked
);
  import keyguard_pkg::*;

  logic key_hit;
  assign key_hit = key_opens(32'(wdata), KEY);

  always_ff @(posedge clk) begin
    if (!rst_n)       locked <= 1'b1;
    else if (wr_lock) locked <= !key_hit;
  end

  // R2
  key_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && key_hit) |=> !locked);
  // R3
  bad_key_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && !key_hit) |=> locked);
  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lock |=> $stable(locked));
endmodule

// File: rtl/keyguard_commit.sv
module keyguard_commit #(
  parameter int SEL_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_commit,
  input  logic              locked,
  input  logic [DATA_W-1:0] wdata,
  output logic [SEL_W-1:0]  commit_mask
);
  logic commit_take;
  assign commit_take = wr_commit && !locked;

  always_ff @(posedge clk) begin
    if (!rst_n)           commit_mask <= '1;
    else if (commit_take) commit_mask <= wdata[SEL_W-1:0];
  end

  // R5
  commit_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && locked) |=> $stable(commit_mask));
  // R4
  commit_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && !locked) |=> commit_mask == $past(wdata[SEL_W-1:0]));
endmodule

// File: rtl/keyguard_fsel.sv
module keyguard_fsel #(
  parameter int SEL_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fsel,
  input  logic [SEL_W-1:0]  commit_mask,
  input  logic [DATA_W-1:0] wdata,
  output logic [SEL_W-1:0]  fsel
);
  import keyguard_pkg::*;

  logic [31:0] merged;
  assign merged = masked_merge(32'(fsel), 32'(wdata[SEL_W-1:0]), 32'(commit_mask));

  always_ff @(posedge clk) begin
    if (!rst_n)       fsel <= '0;
    else if (wr_fsel) fsel <= merged[SEL_W-1:0];
  end

  // R6
  fsel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fsel |=> ((fsel ^ $past(fsel)) & ~$past(commit_mask)) == '0);
  // R6
  fsel_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fsel |=> ((fsel ^ $past(wdata[SEL_W-1:0])) & $past(commit_mask)) == '0);
  // R10
  fsel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fsel |=> $stable(fsel));
endmodule

// File: rtl/keyguard_top.sv
module keyguard_top #(
  parameter int          SEL_W      = 8,
  parameter int          ADDR_W     = 12,
  parameter int          DATA_W     = 32,
  parameter logic [31:0] KEY        = 32'h0ACC_E551,
  parameter int          FSEL_OFF   = 'h420,
  parameter int          LOCK_OFF   = 'h520,
  parameter int          COMMIT_OFF = 'h524
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [SEL_W-1:0]  func_sel
);
  localparam logic [ADDR_W-1:0] A_FSEL   = ADDR_W'(FSEL_OFF);
  localparam logic [ADDR_W-1:0] A_LOCK   = ADDR_W'(LOCK_OFF);
  localparam logic [ADDR_W-1:0] A_COMMIT = ADDR_W'(COMMIT_OFF);

  logic hit_fsel, hit_lock, hit_commit;
  logic wr_fsel, wr_lock, wr_commit;
  logic locked;
  logic [SEL_W-1:0] commit_mask, fsel;

  assign hit_fsel   = addr == A_FSEL;
  assign hit_lock   = addr == A_LOCK;
  assign hit_commit = addr == A_COMMIT;
  assign wr_fsel    = wr_en && hit_fsel;
  assign wr_lock    = wr_en && hit_lock;
  assign wr_commit  = wr_en && hit_commit;

  keyguard_lock #(.DATA_W(DATA_W), .KEY(KEY)) u_lock (
    .clk(clk), .rst_n(rst_n), .wr_lock(wr_lock), .wdata(wdata), .locked(locked));

  keyguard_commit #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_commit (
    .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .locked(locked),
    .wdata(wdata), .commit_mask(commit_mask));

  keyguard_fsel #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_fsel (
    .clk(clk), .rst_n(rst_n), .wr_fsel(wr_fsel), .commit_mask(commit_mask),
    .wdata(wdata), .fsel(fsel));

  always_comb begin
    rdata = '0;
    if (hit_lock)        rdata = DATA_W'(locked);
    else if (hit_commit) rdata = DATA_W'(commit_mask);
    else if (hit_fsel)   rdata = DATA_W'(fsel);
  end

  assign func_sel = fsel;

  // R8
  read_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_lock || hit_commit || hit_fsel) |-> rdata == '0);
  // R10
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(hit_lock || hit_commit || hit_fsel)) |=>
      ($stable(commit_mask) && $stable(locked)));
endmodule

// File: tb/tb_keyguard_top.sv
module tb_keyguard_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  func_sel;

  int errors = 0;
  int checks = 0;
  bit running = 0;

  // behavioural reference
  int m_lock = 1, m_commit = 255, m_fsel = 0;

  always #2.5 clk = ~clk;

  keyguard_top dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                    .wdata(wdata), .rdata(rdata), .func_sel(func_sel));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R9: compare the select output every clock
  always @(negedge clk) if (running) check("R9", int'(func_sel), m_fsel);

  task automatic model_write(int a, logic [31:0] d);
    if (a == 'h520) m_lock = (d == 32'h0ACCE551) ? 0 : 1;
    else if (a == 'h524) begin
      if (m_lock == 0) m_commit = int'(d[7:0]);
    end else if (a == 'h420) begin
      for (int i = 0; i < 8; i++)
        if (m_commit[i]) m_fsel[i] = d[i];
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    addr = 12'(a); wdata = d; wr_en = 1;
    @(posedge clk);
    #1;
    wr_en = 0;
    model_write(a, d);
  endtask

  task automatic rd(int a, int exp, string req);
    @(negedge clk);
    addr = 12'(a);
    #1;
    check(req, int'(rdata), exp);
  endtask

  task automatic rd_all(string req);
    rd('h520, m_lock, req);
    rd('h524, m_commit, req);
    rd('h420, m_fsel, req);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1; running = 1;
    // R1 reset state
    rd('h520, 1, "R1"); rd('h524, 'hFF, "R1"); rd('h420, 0, "R1");
    // R6 full mask while locked
    wr('h420, 32'h0000_00A5); rd('h420, 'hA5, "R6"); rd('h520, 1, "R7");
    // R5 commit write while locked
    wr('h524, 32'h0000_000F); rd('h524, 'hFF, "R5");
    // R3 wrong keys
    wr('h520, 32'h1234_5678); rd('h520, 1, "R3");
    wr('h520, 32'hFACC_E551); rd('h520, 1, "R3");
    // R2 correct key
    wr('h520, 32'h0ACC_E551); rd('h520, 0, "R2");
    // R4 commit write, upper bits dropped
    wr('h524, 32'h0012_30F0); rd('h524, 'hF0, "R4");
    // R7 lock stays open after commit write
    rd('h520, 0, "R7");
    // R6 split mask
    wr('h420, 32'h0000_003C); rd('h420, 'h35, "R6");
    // R6 empty mask
    wr('h524, 32'h0000_0000); wr('h420, 32'hFFFF_FFFF); rd('h420, 'h35, "R6");
    // R10 unmapped write, R8 unmapped read
    wr('h528, 32'hFFFF_FFFF); rd_all("R10");
    rd('h000, 0, "R8"); rd('h41C, 0, "R8");
    // R3 relock with key+1, R5 commit blocked again
    wr('h520, 32'h0ACC_E552); rd('h520, 1, "R3");
    wr('h524, 32'h0000_00FF); rd('h524, 0, "R5");
    wr('h420, 32'h0000_00CA); rd('h420, 'h35, "R6");
    // R4 unlock again and open low nibble only
    wr('h520, 32'h0ACC_E551); wr('h524, 32'h0000_000F);
    wr('h420, 32'h0000_00CA); rd_all("R4");
    rd('h420, 'h3A, "R6");
    running = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule